// File: doc/BRIEF.md
# Fan Tachometer Edge-Count Meter

This block measures fan speed. It counts reference clock cycles across a programmable number of rising edges on the fan's tach line and puts the result in a 16-bit reading. A larger reading means a slower fan. Two saturation codes report fans that are stalled or too slow. A small option register sets the edge count, the slow code and the reading mode. A sticky lock makes that register read-only until the next reset.

In continuous mode the meter runs all the time and takes no notice of the PWM drive. In gated mode it measures only while the associated PWM output is on. A guard delay follows each turn-on, and an option discards the first three edges after the guard expires. If the PWM drops before a measurement finishes, that measurement is abandoned and the previous reading stays. Each completed measurement replaces the reading in a single cycle. The next measurement starts from the edge that closed the previous one.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset `cfg_rdata_o` is 04h and `reading_o` is FFFFh. Option bits [7:5] always read as 0, whatever value was written.
- R2: Option bits [2:1] set the edge count N (00=2, 01=3, 10=5, 11=9). The reading is the number of clock cycles from the first counted rising edge of `tach_i` to the Nth.
- R3: If no counted edge arrives within TIMEOUT_CYCLES clock cycles of the measurement start, the reading becomes FFFFh (stalled), whatever the value of bit 0.
- R4: If at least one edge but fewer than N edges arrive within the window, the reading becomes FFFFh when option bit 0 is 0 and FFFEh when it is 1.
- R5: With option bit 3 = 0 (continuous mode), measurement runs regardless of `pwm_on_i`.
- R6: With option bit 3 = 1 (gated mode), edges that arrive while `pwm_on_i` is low, or in the first GUARD_CYCLES cycles after it goes high, are not used, and the reading does not change while `pwm_on_i` is low.
- R7: In gated mode with option bit 4 = 1, the first three edges after the guard time are discarded before counting starts.
- R8: In gated mode, if `pwm_on_i` falls before N edges are collected, the measurement is dropped and `reading_o` keeps its previous value.
- R9: Once `lock_i` has been high for one cycle, writes to the option register have no effect until reset.
- R10: An accepted option write restarts the measurement. A completed measurement updates `reading_o` in one cycle, and the closing edge starts the next measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tach_i | input | 1 | Fan tach line, asynchronous, synchronised inside |
| pwm_on_i | input | 1 | Associated PWM output is in its on phase |
| cfg_we_i | input | 1 | Option register write strobe |
| cfg_wdata_i | input | 8 | Option register write data |
| cfg_rdata_o | output | 8 | Option register read value |
| lock_i | input | 1 | Sets the sticky option lock |
| reading_o | output | 16 | Latest tach reading |

## Verification
The bench measures every edge-count setting with evenly spaced pulses. It checks that the reading equals (N-1) times the pulse period, so an off-by-one edge or an off-by-one cycle count shows up as a wrong value. It runs stall and slow cases with the slow bit set both ways. A design that mixed up the two saturation codes, or reported a stall as slow, would return FFFEh where FFFFh is due.

In gated mode the bench places one edge inside the guard window. If that edge were counted, the reading would be 167 instead of 160. It then drives three closely spaced edges ahead of wider ones, so failing to skip them gives 75 instead of 180. It also drops the PWM in the middle of a measurement and checks that no stale or stall value replaces the previous reading. Finally it writes the option register after locking and checks that the old edge count still governs the measurement until reset clears the lock.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

  typedef struct packed {
    logic       skip3;
    logic       gated;
    logic [1:0] edge_sel;
    logic       slow_fe;
  } tach_opt_t;

  localparam logic [4:0]  OPT_RESET    = 5'b00100;
  localparam logic [15:0] READ_STALLED = 16'hFFFF;
  localparam logic [15:0] READ_SLOW_FE = 16'hFFFE;

  function automatic logic [3:0] edges_needed(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd2;
      2'b01:   return 4'd3;
      2'b10:   return 4'd5;
      default: return 4'd9;
    endcase
  endfunction

endpackage

// File: rtl/tach_sync_edge.sv
module tach_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tach_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tach_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/tach_opt_reg.sv
module tach_opt_reg
  import fan_tach_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       lock_i,
  output tach_opt_t  opt_o,
  output logic [7:0] rdata_o,
  output logic       restart_o
);
  logic [4:0] opt_q;
  logic       locked_q;
  logic       accept;

  // lock_i gates the write in the same cycle it is raised
  assign accept = we_i & ~locked_q & ~lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_q    <= OPT_RESET;
      locked_q <= 1'b0;
    end else begin
      if (lock_i) locked_q <= 1'b1;
      if (accept) opt_q <= wdata_i[4:0];
    end
  end

  assign opt_o     = tach_opt_t'(opt_q);
  assign rdata_o   = {3'b000, opt_q};
  assign restart_o = accept;
endmodule

// File: rtl/tach_gate.sv
module tach_gate #(
  parameter int GUARD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gated_i,
  input  logic skip3_i,
  input  logic pwm_on_i,
  input  logic rise_i,
  output logic open_o
);
  localparam int GW = $clog2(GUARD_CYCLES + 1);
  localparam logic [GW-1:0] GUARD_END = GW'(GUARD_CYCLES);

  logic [GW-1:0] guard_q;
  logic [1:0]    skip_q;
  logic          guard_done;
  logic          skip_done;

  assign guard_done = (guard_q == GUARD_END);
  assign skip_done  = ~skip3_i | (skip_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guard_q <= '0;
      skip_q  <= '0;
    end else if (!pwm_on_i) begin
      guard_q <= '0;
      skip_q  <= '0;
    end else if (!guard_done) begin
      guard_q <= guard_q + 1'b1;
    end else if (!skip_done && rise_i) begin
      skip_q <= skip_q + 1'b1;
    end
  end

  assign open_o = ~gated_i | (pwm_on_i & guard_done & skip_done);
endmodule

// File: rtl/tach_measure.sv
module tach_measure
  import fan_tach_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 4096,
  parameter int CNT_W          = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             open_i,
  input  logic             restart_i,
  input  logic [3:0]       need_i,
  input  logic             slow_fe_i,
  output logic [CNT_W-1:0] reading_o
);
  localparam int TW = $clog2(TIMEOUT_CYCLES);
  localparam logic [TW-1:0]    TMO_LAST = TW'(TIMEOUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [3:0]       edge_q;
  logic [CNT_W-1:0] cyc_q, cyc_inc;
  logic [TW-1:0]    tmo_q;
  logic [CNT_W-1:0] read_q;
  logic             finish;

  assign cyc_inc = (cyc_q == CNT_MAX) ? CNT_MAX : cyc_q + 1'b1;
  assign finish  = rise_i && (edge_q != 4'd0) && (edge_q + 4'd1 == need_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      cyc_q  <= '0;
      tmo_q  <= '0;
      read_q <= READ_STALLED[CNT_W-1:0];
    end else if (restart_i || !open_i) begin
      edge_q <= '0;
      cyc_q  <= '0;
      tmo_q  <= '0;
    end else if (finish) begin
      read_q <= cyc_inc;
      edge_q <= 4'd1;            // closing edge opens the next window
      cyc_q  <= '0;
      tmo_q  <= '0;
    end else if (tmo_q == TMO_LAST) begin
      if (edge_q == 4'd0)  read_q <= READ_STALLED[CNT_W-1:0];
      else if (slow_fe_i)  read_q <= READ_SLOW_FE[CNT_W-1:0];
      else                 read_q <= READ_STALLED[CNT_W-1:0];
      edge_q <= '0;
      cyc_q  <= '0;
      tmo_q  <= '0;
    end else begin
      tmo_q <= tmo_q + 1'b1;
      if (rise_i && edge_q == 4'd0) begin
        edge_q <= 4'd1;
        cyc_q  <= '0;
      end else begin
        if (rise_i) edge_q <= edge_q + 4'd1;
        cyc_q <= cyc_inc;
      end
    end
  end

  assign reading_o = read_q;
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import fan_tach_pkg::*;
#(
  parameter int GUARD_CYCLES   = 16,
  parameter int TIMEOUT_CYCLES = 4096,
  parameter int SYNC_STAGES    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tach_i,
  input  logic        pwm_on_i,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_wdata_i,
  output logic [7:0]  cfg_rdata_o,
  input  logic        lock_i,
  output logic [15:0] reading_o
);
  tach_opt_t opt;
  logic      restart;
  logic      rise;
  logic      open;

  tach_opt_reg u_opt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .lock_i    (lock_i),
    .opt_o     (opt),
    .rdata_o   (cfg_rdata_o),
    .restart_o (restart)
  );

  tach_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tach_i (tach_i),
    .rise_o (rise)
  );

  tach_gate #(.GUARD_CYCLES(GUARD_CYCLES)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gated_i  (opt.gated),
    .skip3_i  (opt.skip3),
    .pwm_on_i (pwm_on_i),
    .rise_i   (rise),
    .open_o   (open)
  );

  tach_measure #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CNT_W(16)) u_meas (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .open_i    (open),
    .restart_i (restart),
    .need_i    (edges_needed(opt.edge_sel)),
    .slow_fe_i (opt.slow_fe),
    .reading_o (reading_o)
  );
endmodule

// File: rtl/fan_tach_meter_chk.sv
module fan_tach_meter_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pwm_on_i,
  input logic        lock_i,
  input logic [7:0]  cfg_rdata_o,
  input logic [15:0] reading_o
);
  logic lock_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_seen_q <= 1'b0;
    else if (lock_i) lock_seen_q <= 1'b1;
  end

  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[7:5] == 3'b000);

  assert_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reading_o != 16'h0000);

  assert_slow_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reading_o == 16'hFFFE && $past(reading_o) != 16'hFFFE) |-> $past(cfg_rdata_o[0]));

  assert_pwm_off_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[3] && !pwm_on_i) |=> $stable(reading_o));

  assert_lock_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_seen_q |=> $stable(cfg_rdata_o));
endmodule

bind fan_tach_meter fan_tach_meter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwm_on_i    (pwm_on_i),
  .lock_i      (lock_i),
  .cfg_rdata_o (cfg_rdata_o),
  .reading_o   (reading_o)
);

// File: tb/fan_tach_meter_tb.sv
`timescale 1ns/1ps
module fan_tach_meter_tb;
  localparam int TMO = 4096;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tach_i = 1'b0;
  logic        pwm_on_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_wdata_i = 8'h00;
  logic        lock_i = 1'b0;
  logic [7:0]  cfg_rdata_o;
  logic [15:0] reading_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  fan_tach_meter #(.GUARD_CYCLES(16), .TIMEOUT_CYCLES(TMO)) u_dut (
    .clk_i, .rst_ni, .tach_i, .pwm_on_i, .cfg_we_i, .cfg_wdata_i,
    .cfg_rdata_o, .lock_i, .reading_o
  );

  // {cfg, edges, period, expected}
  localparam logic [47:0] VEC [5] = '{
    {8'h04, 8'd5, 16'd40,  16'd160},
    {8'h00, 8'd2, 16'd100, 16'd100},
    {8'h02, 8'd3, 16'd50,  16'd100},
    {8'h06, 8'd9, 16'd30,  16'd240},
    {8'h07, 8'd9, 16'd25,  16'd200}
  };

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    cfg_we_i = 1'b1; cfg_wdata_i = d;
    tick();
    cfg_we_i = 1'b0;
    tick(3);
  endtask

  task automatic pulse(int per);
    tach_i = 1'b1;
    tick(3);
    tach_i = 1'b0;
    tick(per - 3);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    tick(3);
    #5 rst_ni = 1'b1;
    tick(2);
    chk("R1 reset option", {8'h00, cfg_rdata_o}, 16'h0004);
    chk("R1 reset reading", reading_o, 16'hFFFF);

    wr(8'hFF);
    chk("R1 reserved bits", {8'h00, cfg_rdata_o}, 16'h001F);

    // R2 R5 R10: table of edge counts, pwm held low in continuous mode
    for (int i = 0; i < 5; i++) begin
      wr(VEC[i][47:40]);
      for (int k = 0; k < int'(VEC[i][39:32]); k++) pulse(int'(VEC[i][31:16]));
      chk($sformatf("R2 R5 vector %0d", i), reading_o, VEC[i][15:0]);
    end

    // R3: stalled with slow bit set still gives FFFF
    wr(8'h05);
    tick(TMO + 50);
    chk("R3 stalled", reading_o, 16'hFFFF);

    // R4: slow with both codes
    wr(8'h05);
    pulse(40); pulse(40);
    tick(TMO);
    chk("R4 slow FFFE", reading_o, 16'hFFFE);
    wr(8'h04);
    pulse(40); pulse(40);
    tick(TMO);
    chk("R4 slow FFFF", reading_o, 16'hFFFF);

    // R6: gated mode, pwm off ignores edges
    wr(8'h0C);
    for (int k = 0; k < 6; k++) pulse(40);
    chk("R6 pwm off ignored", reading_o, 16'hFFFF);

    // R6: edge inside guard not used
    pwm_on_i = 1'b1;
    tick(3);
    pulse(47);
    for (int k = 0; k < 5; k++) pulse(40);
    chk("R6 guard edge ignored", reading_o, 16'd160);
    pwm_on_i = 1'b0;
    tick(5);

    // R7: three short edges discarded
    wr(8'h1C);
    pwm_on_i = 1'b1;
    tick(20);
    for (int k = 0; k < 3; k++) pulse(10);
    for (int k = 0; k < 5; k++) pulse(45);
    chk("R7 skip three", reading_o, 16'd180);
    pwm_on_i = 1'b0;
    tick(5);

    // R8: abandoned measurement keeps previous reading
    wr(8'h0C);
    pwm_on_i = 1'b1;
    tick(20);
    pulse(40); pulse(40);
    pwm_on_i = 1'b0;
    tick(TMO + 50);
    chk("R8 abort keeps reading", reading_o, 16'd180);

    // R9: lock freezes option register
    wr(8'h02);
    chk("R9 pre-lock write", {8'h00, cfg_rdata_o}, 16'h0002);
    lock_i = 1'b1; tick(); lock_i = 1'b0;
    wr(8'h06);
    chk("R9 locked write ignored", {8'h00, cfg_rdata_o}, 16'h0002);
    for (int k = 0; k < 3; k++) pulse(50);
    chk("R9 locked edge count", reading_o, 16'd100);

    rst_ni = 1'b0;
    tick(2);
    rst_ni = 1'b1;
    tick(2);
    chk("R1 option after reset", {8'h00, cfg_rdata_o}, 16'h0004);
    wr(8'h00);
    chk("R9 lock cleared by reset", {8'h00, cfg_rdata_o}, 16'h0000);

    // R10: write restarts, spacing changes mid-run
    pulse(60); pulse(30);
    chk("R10 restart measure", reading_o, 16'd60);
    pulse(30);
    chk("R10 chained measure", reading_o, 16'd30);

    summary();
  end
endmodule